// File: doc/BRIEF.md
# Configuration Register Access Port

This block gives a host access to per-function configuration registers through two paths. The I/O path is an address/data pair. A dword is written to the address port to select a bus, device, function and register dword, and accesses to the data port then reach that register. The memory-mapped path carries bus, device, function and a 12-bit byte offset in the request address, so it reaches the full 4 KB of each function. Requests are decoded in the cycle they arrive. Legal data accesses come out at once as a register-file request with byte enables. A response follows one cycle later.

The port checks access width against the region. It steers sub-dword data to the byte lanes given by the low address bits, in little-endian order. Through a writable-bit mask that the register file returns, it forces reserved bits to zero on writes and on reads. Illegal accesses are answered with an error flag and all-ones data, and the register file is not touched.

Top module: `cfg_window_port`

## Requirements
- R1: Offsets 0 to 255 accept byte (size 0), word (size 1) and dword (size 2) accesses on both paths. Read data is returned right-justified, with the bytes above the access size at zero.
- R2: Byte order is little-endian. An access of size S at byte offset N (address bits [1:0]) uses register lanes N up to N+S-1. `rf_be` bit i enables bits [8i+7:8i], and write data is shifted left by 8*N bits.
- R3: Offsets 256 to 4095 are reached only on the memory-mapped path and only as dwords. A byte or word access there returns `rsp_err`=1 with data 0xFFFFFFFF and raises no `rf_req`. A memory-mapped address is {bus[27:20], device[19:15], function[14:12], offset[11:0]}, and these fields appear on `rf_bus`, `rf_dev`, `rf_fn` and `rf_dw`=offset[11:2].
- R4: On the I/O path, address bit 2 clear selects the address port. It accepts only a dword at offset 0. A narrower write there is ignored, a narrower read returns 0xFFFFFFFF, and neither raises an error.
- R5: The address port holds enable in bit 31, extension dword bits in [27:24], bus in [23:16], device in [15:11], function in [10:8] and register dword in [7:2]. A write stores the masked value directly, with no read-merge. Bits [30:28] and [1:0] read as zero.
- R6: On the I/O path, address bit 2 set selects the data port. While the enable bit is clear, a read there returns 0xFFFFFFFF, a write does nothing, no `rf_req` is raised and no error is flagged.
- R7: A data-port access while the extension bits [27:24] are non-zero targets the extended region. It is rejected with `rsp_err`=1 and raises no `rf_req`.
- R8: Bits cleared in `rf_mask` are driven as zero on `rf_wdata` and read back as zero.
- R9: An access whose lanes pass byte 3 of the dword (offset + size > 4), or one with size code 3, is rejected with `rsp_err`=1 and raises no `rf_req`.
- R10: Each request cycle is followed by exactly one cycle of `rsp_valid`. Erroring requests return data 0xFFFFFFFF, and accepted writes return 0.
- R11: After reset the address port reads 0 (enable clear) and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_io | input | 1 | 1: I/O path, 0: memory-mapped path |
| req_write | input | 1 | 1: write, 0: read |
| req_size | input | 2 | 0 byte, 1 word, 2 dword, 3 invalid |
| req_addr | input | 28 | I/O: bit 2 selects the port, [1:0] the byte offset. Memory: {bus, device, function, offset} |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, right-justified |
| rsp_err | output | 1 | Request was rejected |
| rf_req | output | 1 | Register-file access |
| rf_we | output | 1 | Register-file write |
| rf_bus | output | 8 | Target bus |
| rf_dev | output | 5 | Target device |
| rf_fn | output | 3 | Target function |
| rf_dw | output | 10 | Target dword index within the function |
| rf_be | output | 4 | Byte enables |
| rf_wdata | output | 32 | Lane-steered, masked write data |
| rf_rdata | input | 32 | Register contents at `rf_dw`, same cycle |
| rf_mask | input | 32 | Writable-bit mask of the register at `rf_dw` |

## Verification
The hardest condition to reach is an I/O data-port access that targets the extended region. It needs an earlier address-port write that sets both the enable bit and non-zero extension bits, and only then a data-port access. The bench runs that sequence and checks that the error flag is set and that the register-file access count does not move. Rejected narrow writes to the extended region are checked in a similar way. The bench writes a known dword there first, attempts the illegal word write, and then reads the dword back to show it is unchanged.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
    localparam int DW      = 32;
    localparam int BYTES   = DW / 8;
    localparam int BUS_W   = 8;
    localparam int DEV_W   = 5;
    localparam int FN_W    = 3;
    localparam int OFF_W   = 12;
    localparam int DWA_W   = OFF_W - 2;
    localparam int EXT_W   = 4;
    localparam int REG_W   = DWA_W - EXT_W;
    localparam int ADDR_W  = BUS_W + DEV_W + FN_W + OFF_W;

    // address port layout
    localparam int EN_BIT  = 31;
    localparam int EXT_LSB = 24;
    localparam int BUS_LSB = 16;
    localparam int DEV_LSB = 11;
    localparam int FN_LSB  = 8;
    localparam int REG_LSB = 2;
    localparam logic [DW-1:0] ADR_KEEP = 32'h8FFF_FFFC;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        K_DATA,
        K_ADR_OK,
        K_ADR_BAD,
        K_DEAD,
        K_ERR
    } kind_e;

    typedef struct packed {
        logic          valid;
        logic          err;
        logic [DW-1:0] rdata;
    } rsp_t;

    typedef struct packed {
        logic [DW-1:0] adr;
        rsp_t          rsp;
    } state_t;
endpackage

// File: rtl/cfgw_decode.sv
module cfgw_decode
    import cfgw_pkg::*;
#(
    parameter int LOW_BYTES = 256
) (
    input  logic              req_io,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     adr_q,
    output kind_e             kind,
    output logic [BUS_W-1:0]  tgt_bus,
    output logic [DEV_W-1:0]  tgt_dev,
    output logic [FN_W-1:0]   tgt_fn,
    output logic [DWA_W-1:0]  tgt_dw,
    output logic [1:0]        byte_off,
    output logic [BYTES-1:0]  be
);
    localparam logic [OFF_W-1:0] LOW_LIM = OFF_W'(LOW_BYTES);

    logic [2:0]       nbytes;
    logic [2:0]       lane_end;
    logic             crosses;
    logic             size_bad;
    logic [7:0]       be_wide;
    logic [OFF_W-1:0] off12;
    logic [EXT_W-1:0] ext;
    logic             unused_adr;

    assign off12      = req_addr[OFF_W-1:0];
    assign ext        = adr_q[EXT_LSB +: EXT_W];
    assign byte_off   = req_addr[1:0];
    assign unused_adr = ^{adr_q[30:28], adr_q[1:0]};

    always_comb begin
        case (size_e'(req_size))
            SZ_BYTE:  nbytes = 3'd1;
            SZ_WORD:  nbytes = 3'd2;
            SZ_DWORD: nbytes = 3'd4;
            default:  nbytes = 3'd0;
        endcase
        size_bad = (size_e'(req_size) == SZ_BAD);
        lane_end = {1'b0, byte_off} + nbytes;
        crosses  = lane_end > 3'd4;
        be_wide  = ((8'd1 << nbytes) - 8'd1) << byte_off;
        be       = be_wide[BYTES-1:0];
    end

    always_comb begin
        tgt_bus = '0;
        tgt_dev = '0;
        tgt_fn  = '0;
        tgt_dw  = '0;
        if (req_io) begin
            tgt_bus = adr_q[BUS_LSB +: BUS_W];
            tgt_dev = adr_q[DEV_LSB +: DEV_W];
            tgt_fn  = adr_q[FN_LSB +: FN_W];
            tgt_dw  = {ext, adr_q[REG_LSB +: REG_W]};
            if (!req_addr[2]) begin
                if (size_e'(req_size) == SZ_DWORD && byte_off == 2'd0)
                    kind = K_ADR_OK;
                else
                    kind = K_ADR_BAD;
            end else if (!adr_q[EN_BIT]) begin
                kind = K_DEAD;
            end else if (ext != '0 || size_bad || crosses) begin
                kind = K_ERR;
            end else begin
                kind = K_DATA;
            end
        end else begin
            tgt_bus = req_addr[OFF_W+FN_W+DEV_W +: BUS_W];
            tgt_dev = req_addr[OFF_W+FN_W +: DEV_W];
            tgt_fn  = req_addr[OFF_W +: FN_W];
            tgt_dw  = off12[OFF_W-1:2];
            if (size_bad || crosses)
                kind = K_ERR;
            else if (off12 >= LOW_LIM && size_e'(req_size) != SZ_DWORD)
                kind = K_ERR;
            else
                kind = K_DATA;
        end
    end
endmodule

// File: rtl/cfgw_lanes.sv
module cfgw_lanes
    import cfgw_pkg::*;
(
    input  logic [1:0]       byte_off,
    input  logic [1:0]       req_size,
    input  logic [BYTES-1:0] be,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    rdata,
    input  logic [DW-1:0]    mask,
    output logic [DW-1:0]    wlane,
    output logic [DW-1:0]    rjust
);
    logic [DW-1:0] be_bits;
    logic [DW-1:0] size_bits;
    logic [4:0]    shamt;

    assign shamt = {byte_off, 3'b000};

    genvar gi;
    generate
        for (gi = 0; gi < BYTES; gi++) begin : g_lane
            assign be_bits[8*gi +: 8] = {8{be[gi]}};
        end
    endgenerate

    always_comb begin
        case (size_e'(req_size))
            SZ_BYTE: size_bits = DW'(8'hFF);
            SZ_WORD: size_bits = DW'(16'hFFFF);
            default: size_bits = '1;
        endcase
        wlane = (wdata << shamt) & be_bits & mask;
        rjust = ((rdata & mask) >> shamt) & size_bits;
    end
endmodule

// File: rtl/cfg_window_port.sv
module cfg_window_port
    import cfgw_pkg::*;
#(
    parameter int LOW_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_io,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    output logic              rsp_err,
    output logic              rf_req,
    output logic              rf_we,
    output logic [BUS_W-1:0]  rf_bus,
    output logic [DEV_W-1:0]  rf_dev,
    output logic [FN_W-1:0]   rf_fn,
    output logic [DWA_W-1:0]  rf_dw,
    output logic [BYTES-1:0]  rf_be,
    output logic [DW-1:0]     rf_wdata,
    input  logic [DW-1:0]     rf_rdata,
    input  logic [DW-1:0]     rf_mask
);
    state_t        st_d, st_q;
    kind_e         kind;
    logic [1:0]    byte_off;
    logic [DW-1:0] rjust;

    cfgw_decode #(.LOW_BYTES(LOW_BYTES)) u_dec (
        .req_io   (req_io),
        .req_size (req_size),
        .req_addr (req_addr),
        .adr_q    (st_q.adr),
        .kind     (kind),
        .tgt_bus  (rf_bus),
        .tgt_dev  (rf_dev),
        .tgt_fn   (rf_fn),
        .tgt_dw   (rf_dw),
        .byte_off (byte_off),
        .be       (rf_be)
    );

    cfgw_lanes u_lanes (
        .byte_off (byte_off),
        .req_size (req_size),
        .be       (rf_be),
        .wdata    (req_wdata),
        .rdata    (rf_rdata),
        .mask     (rf_mask),
        .wlane    (rf_wdata),
        .rjust    (rjust)
    );

    assign rf_req    = req_valid && (kind == K_DATA);
    assign rf_we     = rf_req && req_write;
    assign rsp_valid = st_q.rsp.valid;
    assign rsp_err   = st_q.rsp.err;
    assign rsp_rdata = st_q.rsp.rdata;

    always_comb begin
        st_d           = st_q;
        st_d.rsp.valid = req_valid;
        st_d.rsp.err   = 1'b0;
        st_d.rsp.rdata = '0;
        if (req_valid) begin
            case (kind)
                K_ADR_OK: begin
                    if (req_write) st_d.adr       = req_wdata & ADR_KEEP;
                    else           st_d.rsp.rdata = st_q.adr;
                end
                K_ADR_BAD, K_DEAD: begin
                    if (!req_write) st_d.rsp.rdata = '1;
                end
                K_ERR: begin
                    st_d.rsp.err   = 1'b1;
                    st_d.rsp.rdata = '1;
                end
                default: begin
                    if (!req_write) st_d.rsp.rdata = rjust;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cfg_window_port_chk.sv
module cfg_window_port_chk
    import cfgw_pkg::*;
#(
    parameter int LOW_BYTES = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic [DW-1:0]    rsp_rdata,
    input logic             rf_req,
    input logic             rf_we,
    input logic [DWA_W-1:0] rf_dw,
    input logic [BYTES-1:0] rf_be,
    input logic [DW-1:0]    rf_wdata,
    input logic [DW-1:0]    rf_mask
);
    localparam logic [DWA_W-1:0] LOW_DW = DWA_W'(LOW_BYTES / BYTES);

    logic [DW-1:0] be_bits;
    always_comb begin
        for (int i = 0; i < BYTES; i++) be_bits[8*i +: 8] = {8{rf_be[i]}};
    end

    // R3
    ext_dword_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && rf_dw >= LOW_DW) |-> (rf_be == '1));

    // R2
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req |-> ($countones(rf_be) == 1 || $countones(rf_be) == 2 || rf_be == '1));

    // R2
    lane_outside_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> ((rf_wdata & ~be_bits) == '0));

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> ((rf_wdata & ~rf_mask) == '0));

    // R10
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R9
    err_no_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (!$past(rf_req) && rsp_rdata == '1));
endmodule

bind cfg_window_port cfg_window_port_chk #(.LOW_BYTES(LOW_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .rf_req    (rf_req),
    .rf_we     (rf_we),
    .rf_dw     (rf_dw),
    .rf_be     (rf_be),
    .rf_wdata  (rf_wdata),
    .rf_mask   (rf_mask)
);

// File: tb/cfg_window_port_bench.sv
`timescale 1ns/1ps
module cfg_window_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_io = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [27:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, rf_req, rf_we;
    logic [31:0] rsp_rdata, rf_wdata, rf_rdata, rf_mask;
    logic [7:0]  rf_bus;
    logic [4:0]  rf_dev;
    logic [2:0]  rf_fn;
    logic [9:0]  rf_dw;
    logic [3:0]  rf_be;

    int checks = 0, errors = 0;
    int rf_cnt = 0;
    logic [31:0] mem [16];
    logic [3:0]  last_be;
    logic [31:0] last_wdata;
    logic [7:0]  last_bus;
    logic [4:0]  last_dev;
    logic [2:0]  last_fn;

    always #10 clk = ~clk;

    cfg_window_port u_cfg_window_port (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_io(req_io),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .rf_req(rf_req), .rf_we(rf_we), .rf_bus(rf_bus),
        .rf_dev(rf_dev), .rf_fn(rf_fn), .rf_dw(rf_dw), .rf_be(rf_be),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .rf_mask(rf_mask)
    );

    // register-file model: dword 3 has writable mask 0x0000FF0F
    assign rf_rdata = mem[rf_dw[3:0]];
    assign rf_mask  = (rf_dw == 10'd3) ? 32'h0000_FF0F : 32'hFFFF_FFFF;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= '0;
        end else if (rf_req) begin
            rf_cnt     <= rf_cnt + 1;
            last_be    <= rf_be;
            last_bus   <= rf_bus;
            last_dev   <= rf_dev;
            last_fn    <= rf_fn;
            if (rf_we) begin
                last_wdata <= rf_wdata;
                for (int b = 0; b < 4; b++)
                    if (rf_be[b]) mem[rf_dw[3:0]][8*b +: 8] <= rf_wdata[8*b +: 8];
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [27:0] mm(input logic [7:0] b, input logic [4:0] d,
                                       input logic [2:0] f, input logic [11:0] o);
        return {b, d, f, o};
    endfunction

    task automatic access(input bit io, input bit wr, input logic [1:0] sz,
                          input logic [27:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output logic er);
        @(negedge clk);
        req_valid = 1'b1; req_io = io; req_write = wr;
        req_size = sz; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        rd = rsp_rdata;
        er = rsp_err;
        chk("R10 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] rd; logic er;
        chk("R11 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        access(1, 0, 2, 28'h0, '0, rd, er);
        chk("R11 address port after reset", rd, 32'h0);
    endtask

    task automatic t_adr();
        logic [31:0] rd; logic er;
        access(1, 1, 2, 28'h0, 32'hFFFF_FFFF, rd, er);
        access(1, 0, 2, 28'h0, '0, rd, er);
        chk("R5 reserved bits of address port", rd, 32'h8FFF_FFFC);
        access(1, 1, 0, 28'h0, 32'h0000_0000, rd, er);
        access(1, 1, 1, 28'h0, 32'h0000_0000, rd, er);
        chk("R4 narrow write no error", {31'd0, er}, 32'd0);
        access(1, 0, 2, 28'h0, '0, rd, er);
        chk("R4 narrow write ignored", rd, 32'h8FFF_FFFC);
        access(1, 0, 0, 28'h0, '0, rd, er);
        chk("R4 narrow read all ones", rd, 32'hFFFF_FFFF);
        access(1, 1, 2, 28'h0, 32'h0000_0000, rd, er);
    endtask

    task automatic t_disabled();
        logic [31:0] rd; logic er; int c0;
        c0 = rf_cnt;
        access(1, 0, 2, 28'h4, '0, rd, er);
        chk("R6 disabled read all ones", rd, 32'hFFFF_FFFF);
        access(1, 1, 2, 28'h4, 32'h1234_5678, rd, er);
        chk("R6 disabled no error", {31'd0, er}, 32'd0);
        chk("R6 disabled no access", rf_cnt - c0, 32'd0);
    endtask

    task automatic t_io_rw();
        logic [31:0] rd; logic er;
        access(1, 1, 2, 28'h0, 32'h8001_0008, rd, er);  // bus 1, dword 2
        access(1, 1, 2, 28'h4, 32'h1122_3344, rd, er);
        chk("R1 io dword write bus", {24'd0, last_bus}, 32'h1);
        access(1, 0, 0, 28'h6, '0, rd, er);
        chk("R2 byte read offset 2", rd, 32'h22);
        access(1, 0, 1, 28'h5, '0, rd, er);
        chk("R2 word read offset 1", rd, 32'h2233);
        access(1, 1, 0, 28'h7, 32'h0000_00AA, rd, er);
        chk("R2 byte write lane 3 enable", {28'd0, last_be}, 32'h8);
        access(1, 0, 2, 28'h4, '0, rd, er);
        chk("R1 dword after byte write", rd, 32'hAA22_3344);
        access(1, 1, 1, 28'h4, 32'h0, rd, er);
        chk("R10 accepted write returns 0", rd, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] rd; logic er;
        access(0, 1, 2, mm(0, 0, 0, 12'h00C), 32'hFFFF_FFFF, rd, er);
        chk("R8 reserved write data zero", last_wdata, 32'h0000_FF0F);
        access(0, 0, 2, mm(0, 0, 0, 12'h00C), '0, rd, er);
        chk("R8 reserved read zero", rd, 32'h0000_FF0F);
    endtask

    task automatic t_ext();
        logic [31:0] rd; logic er; int c0;
        access(0, 1, 2, mm(8'h2, 5'h3, 3'h1, 12'h104), 32'hCAFE_F00D, rd, er);
        chk("R3 ext dword write ok", {31'd0, er}, 32'd0);
        chk("R3 target fields", {16'd0, last_bus, 3'd0, last_dev}, {16'd0, 8'h2, 3'd0, 5'h3});
        chk("R3 target function", {29'd0, last_fn}, 32'h1);
        c0 = rf_cnt;
        access(0, 0, 0, mm(8'h2, 5'h3, 3'h1, 12'h105), '0, rd, er);
        chk("R3 ext byte read error", {31'd0, er}, 32'd1);
        chk("R3 ext byte read ones", rd, 32'hFFFF_FFFF);
        access(0, 1, 1, mm(8'h2, 5'h3, 3'h1, 12'h106), 32'h0000_0000, rd, er);
        chk("R3 ext word write error", {31'd0, er}, 32'd1);
        chk("R3 no access on reject", rf_cnt - c0, 32'd0);
        access(0, 0, 2, mm(8'h2, 5'h3, 3'h1, 12'h104), '0, rd, er);
        chk("R3 ext dword unchanged", rd, 32'hCAFE_F00D);
    endtask

    task automatic t_io_ext();
        logic [31:0] rd; logic er; int c0;
        access(1, 1, 2, 28'h0, 32'h8100_0004, rd, er);
        c0 = rf_cnt;
        access(1, 0, 2, 28'h4, '0, rd, er);
        chk("R7 io extended read error", {31'd0, er}, 32'd1);
        access(1, 1, 2, 28'h4, 32'h5555_5555, rd, er);
        chk("R7 io extended write error", {31'd0, er}, 32'd1);
        chk("R7 io extended no access", rf_cnt - c0, 32'd0);
    endtask

    task automatic t_cross();
        logic [31:0] rd; logic er; int c0;
        c0 = rf_cnt;
        access(0, 0, 1, mm(0, 0, 0, 12'h003), '0, rd, er);
        chk("R9 word crossing error", {31'd0, er}, 32'd1);
        access(0, 0, 2, mm(0, 0, 0, 12'h002), '0, rd, er);
        chk("R9 dword misaligned error", {31'd0, er}, 32'd1);
        access(0, 0, 3, mm(0, 0, 0, 12'h000), '0, rd, er);
        chk("R9 size code 3 error", {31'd0, er}, 32'd1);
        chk("R9 no access", rf_cnt - c0, 32'd0);
        access(0, 0, 1, mm(0, 0, 0, 12'h00A), '0, rd, er);
        chk("R1 mm word read offset 2", rd, 32'h0000_AA22);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_adr();
        t_disabled();
        t_io_rw();
        t_mask();
        t_ext();
        t_io_ext();
        t_cross();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule